// File: doc/BRIEF.md
# Buffered Full-Duplex Serial Peripheral Master

This block is a serial peripheral interface master that moves up to 512 bits per transfer. It sends from, and receives into, one buffer of sixteen 32-bit words. Software fills the buffer through a word-wide register port. It then programs the clock divisor, the polarity and phase, and two independent bit lengths: one for the outgoing stream and one for the incoming stream. Writing the start bit launches the transfer. The block lowers its single active-low select line, runs the serial clock for as many bits as the longer of the two lengths, and then releases the select line. Received bits overwrite the buffer in place, so the buffer holds the reply when the busy flag drops.

When both lengths are equal, each bit shifted out is matched by one bit shifted in. A short command followed by a long reply is run by setting the outgoing length short and the incoming length long. The serial clock is the system clock divided by an even number from 2 to 65536.

Top module: `spim_ctrl`

## Requirements
- R1: While idle, a write to register address 0..15 stores the whole data word in buffer word 0..15, and a read of that address returns it.
- R2: Address 16 is the command register. Writing it with bit 0 set while idle starts a transfer. Bit 0 reads 1 for as long as the transfer runs and 0 afterwards. Bit 1 reads 1 once a transfer has finished and is cleared by the next start.
- R3: Address 17 bits [15:0] hold the divisor field D. Each SCLK high and low phase lasts H system clocks, where H = D/2 rounded down for D >= 2, and H = 32768 for D = 0 or D = 1.
- R4: Address 17 bit 16 is the clock polarity. While the select line is high, SCLK rests at the polarity value.
- R5: Address 17 bit 17 is the clock phase. With phase 0, MOSI is valid from the select falling edge, each leading SCLK edge samples and each trailing edge shifts. With phase 1, leading edges shift and trailing edges sample. Bit i of the stream is bit 31-(i mod 32) of word i/32, so the stream starts with the MSB of word 0.
- R6: Addresses 18 and 19 hold the outgoing and incoming lengths as bit count minus one (0..511). A transfer lasts N = max(outgoing, incoming) + 1 bits and produces exactly 2N SCLK edges.
- R7: Stream bits beyond the outgoing length are driven as 0 on MOSI.
- R8: The MISO value at sampling edge i is written over stream bit i of the buffer for i up to the incoming length. Buffer bits beyond the incoming length keep their transmitted contents.
- R9: The select line falls when the start is written. The first SCLK edge comes H clocks later, and the select line rises H clocks after the last edge.
- R10: While busy, writes to the buffer, to addresses 17..19 and to the command register have no effect.
- R11: After reset the select line is high, SCLK and MOSI are low, and every register and buffer word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the peripheral |
| miso_i | input | 1 | Serial data from the peripheral |
| cs_n_o | output | 1 | Active-low select |

## Verification
The assertions assume that the polarity input holds still during a transfer. They also assume that no start request arrives in the same cycle as a buffer write, which the register port guarantees because it carries one address per cycle. The bench changes configuration only between transfers, and every write it makes while busy targets state that the block must protect. Its peripheral model changes MISO on the shifting edges only, so the value the block samples is always at least one system clock old. The bench sweeps all four clock modes against several even and odd divisors and four length pairings. The divisors of 0 and 1 are checked only up to the first edge, followed by a reset.

// File: rtl/spim_pkg.sv
package spim_pkg;

   // sequencer phases of one transfer
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_SETUP = 2'd1,
      SQ_RUN   = 2'd2,
      SQ_HOLD  = 2'd3
   } sq_state_e;

   // control register offsets above the buffer window
   localparam int unsigned CTL_CMD  = 0;
   localparam int unsigned CTL_CFG  = 1;
   localparam int unsigned CTL_OLEN = 2;
   localparam int unsigned CTL_ILEN = 3;

   // command register bit positions
   localparam int unsigned CMD_GO   = 0;
   localparam int unsigned CMD_DONE = 1;

endpackage

// File: rtl/spim_div.sv
module spim_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic             active_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] half;
   logic [DIV_W-1:0] cnt_q;

   if (DIV_W < 2) begin : g_chk_w
      $error("spim_div: DIV_W must be at least 2");
   end

   // zero and one select the largest divisor; odd values lose their low bit
   always_comb begin
      if (div_i < DIV_W'(2)) half = {1'b1, {(DIV_W-1){1'b0}}};
      else                   half = div_i >> 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (!active_i || cnt_q == '0) cnt_q <= half - 1'b1;
      else                               cnt_q <= cnt_q - 1'b1;
   end

   assign tick_o = active_i && (cnt_q == '0);

endmodule

// File: rtl/spim_buf.sv
module spim_buf #(
   parameter  int WORDS  = 16,
   parameter  int WORD_W = 32,
   localparam int WI_W   = $clog2(WORDS),
   localparam int BI_W   = $clog2(WORDS * WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we_i,
   input  logic [WI_W-1:0]   sw_idx_i,
   input  logic [WORD_W-1:0] sw_wdata_i,
   output logic [WORD_W-1:0] sw_rdata_o,
   input  logic [BI_W-1:0]   rd_idx_i,
   output logic              rd_bit_o,
   input  logic              wr_we_i,
   input  logic [BI_W-1:0]   wr_idx_i,
   input  logic              wr_bit_i
);

   localparam int POS_W = $clog2(WORD_W);

   logic [WORD_W-1:0] words [WORDS];
   logic [WI_W-1:0]   rd_w, wr_w;
   logic [POS_W-1:0]  rd_p, wr_p;

   // stream bit k sits at word k/W, position W-1-(k mod W)
   assign rd_w = rd_idx_i[BI_W-1:POS_W];
   assign wr_w = wr_idx_i[BI_W-1:POS_W];
   assign rd_p = ~rd_idx_i[POS_W-1:0];
   assign wr_p = ~wr_idx_i[POS_W-1:0];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                word_q <= '0;
         else if (sw_we_i && sw_idx_i == WI_W'(g))  word_q <= sw_wdata_i;
         else if (wr_we_i && wr_w == WI_W'(g))      word_q[wr_p] <= wr_bit_i;
      end
      assign words[g] = word_q;
   end

   assign sw_rdata_o = words[sw_idx_i];
   assign rd_bit_o   = words[rd_w][rd_p];

   // receive writes come only from a running transfer, when the port is locked
   assert_no_sw_write_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_we_i |-> !sw_we_i);

endmodule

// File: rtl/spim_seq.sv
module spim_seq
   import spim_pkg::*;
#(
   parameter int LEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             tick_i,
   input  logic             cpol_i,
   input  logic             cpha_i,
   input  logic [LEN_W-1:0] olen_i,
   input  logic [LEN_W-1:0] ilen_i,
   input  logic             tx_bit_i,
   input  logic             miso_i,
   output logic             busy_o,
   output logic             finish_o,
   output logic             sclk_o,
   output logic             mosi_o,
   output logic             cs_n_o,
   output logic [LEN_W-1:0] tx_rd_idx_o,
   output logic             rx_we_o,
   output logic [LEN_W-1:0] rx_idx_o,
   output logic             rx_bit_o
);

   localparam int IDX_W = LEN_W + 1;

   sq_state_e        state_q;
   logic [IDX_W-1:0] ec_q;     // edge number within the transfer
   logic [IDX_W-1:0] ptr_q;    // next stream bit to put on MOSI
   logic [IDX_W-1:0] rptr_q;   // next stream bit to capture
   logic             sclk_q, mosi_q, cs_q;

   logic [LEN_W-1:0] span;
   logic [IDX_W-1:0] last_ec;
   logic             edge_now, lead, smp, tx_ok;

   assign span     = (olen_i > ilen_i) ? olen_i : ilen_i;
   assign last_ec  = {span, 1'b1};
   assign edge_now = tick_i && (state_q == SQ_SETUP || state_q == SQ_RUN);
   assign lead     = ~ec_q[0];
   assign smp      = lead ^ cpha_i;
   assign tx_ok    = ptr_q <= {1'b0, olen_i};

   assign rx_we_o     = edge_now && smp && (rptr_q <= {1'b0, ilen_i});
   assign rx_idx_o    = rptr_q[LEN_W-1:0];
   assign rx_bit_o    = miso_i;
   assign tx_rd_idx_o = (state_q == SQ_IDLE) ? '0 : ptr_q[LEN_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         sclk_q  <= 1'b0;
         mosi_q  <= 1'b0;
         cs_q    <= 1'b1;
         ec_q    <= '0;
         ptr_q   <= '0;
         rptr_q  <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               sclk_q <= cpol_i;
               mosi_q <= 1'b0;
               if (start_i) begin
                  state_q <= SQ_SETUP;
                  cs_q    <= 1'b0;
                  ec_q    <= '0;
                  rptr_q  <= '0;
                  ptr_q   <= cpha_i ? IDX_W'(0) : IDX_W'(1);
                  mosi_q  <= cpha_i ? 1'b0 : tx_bit_i;
               end
            end
            SQ_SETUP, SQ_RUN: begin
               if (tick_i) begin
                  sclk_q <= ~sclk_q;
                  ec_q   <= ec_q + 1'b1;
                  if (smp) begin
                     rptr_q <= rptr_q + 1'b1;
                  end else begin
                     mosi_q <= tx_ok ? tx_bit_i : 1'b0;
                     ptr_q  <= ptr_q + 1'b1;
                  end
                  state_q <= (ec_q == last_ec) ? SQ_HOLD : SQ_RUN;
               end
            end
            SQ_HOLD: begin
               if (tick_i) begin
                  cs_q    <= 1'b1;
                  mosi_q  <= 1'b0;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o   = (state_q != SQ_IDLE);
   assign finish_o = tick_i && (state_q == SQ_HOLD);
   assign sclk_o   = sclk_q;
   assign mosi_o   = mosi_q;
   assign cs_n_o   = cs_q;

   assert_sclk_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SQ_IDLE && $past(state_q) != SQ_IDLE && !$stable(sclk_q)) |-> $past(tick_i));

   assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_o && $past(cs_n_o) && $stable(cpol_i)) |-> (sclk_o == cpol_i));

   assert_edges_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_RUN) |-> (ec_q <= last_ec));

   assert_mosi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SQ_IDLE && ptr_q > ({1'b0, olen_i} + 1'b1)) |-> !mosi_o);

   assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> ($past(state_q) == SQ_HOLD));

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
   import spim_pkg::*;
#(
   parameter  int WORDS  = 16,
   parameter  int WORD_W = 32,
   parameter  int DIV_W  = 16,
   localparam int AW     = $clog2(WORDS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [AW-1:0]     reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              sclk_o,
   output logic              mosi_o,
   input  logic              miso_i,
   output logic              cs_n_o
);

   localparam int WI_W  = AW - 1;
   localparam int LEN_W = $clog2(WORDS * WORD_W);

   if ((1 << WI_W) != WORDS || WORDS < 4) begin : g_chk_words
      $error("spim_ctrl: WORDS must be a power of two of at least 4");
   end
   if ((1 << $clog2(WORD_W)) != WORD_W) begin : g_chk_wordw
      $error("spim_ctrl: WORD_W must be a power of two");
   end
   if (DIV_W + 2 > WORD_W || LEN_W > WORD_W) begin : g_chk_fields
      $error("spim_ctrl: configuration fields do not fit one word");
   end

   logic             busy, finish, tick;
   logic             done_q, cpol_q, cpha_q;
   logic [DIV_W-1:0] div_q;
   logic [LEN_W-1:0] olen_q, ilen_q;

   logic             sw_ok, is_ctl, buf_we, start_req;
   logic [WI_W-1:0]  ofs;
   logic [WORD_W-1:0] buf_rdata, ctl_rdata;

   logic             tx_bit, rx_we, rx_bit;
   logic [LEN_W-1:0] tx_idx, rx_idx;

   assign sw_ok     = reg_we && !busy;
   assign is_ctl    = reg_addr[AW-1];
   assign ofs       = reg_addr[AW-2:0];
   assign buf_we    = sw_ok && !is_ctl;
   assign start_req = sw_ok && is_ctl && ofs == WI_W'(CTL_CMD) && reg_wdata[CMD_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
         div_q  <= '0;
         olen_q <= '0;
         ilen_q <= '0;
      end else begin
         if (finish)    done_q <= 1'b1;
         if (start_req) done_q <= 1'b0;
         if (sw_ok && is_ctl) begin
            if (ofs == WI_W'(CTL_CFG)) begin
               div_q  <= reg_wdata[DIV_W-1:0];
               cpol_q <= reg_wdata[DIV_W];
               cpha_q <= reg_wdata[DIV_W+1];
            end
            if (ofs == WI_W'(CTL_OLEN)) olen_q <= reg_wdata[LEN_W-1:0];
            if (ofs == WI_W'(CTL_ILEN)) ilen_q <= reg_wdata[LEN_W-1:0];
         end
      end
   end

   always_comb begin
      ctl_rdata = '0;
      if (ofs == WI_W'(CTL_CMD)) begin
         ctl_rdata[CMD_GO]   = busy;
         ctl_rdata[CMD_DONE] = done_q;
      end else if (ofs == WI_W'(CTL_CFG)) begin
         ctl_rdata[DIV_W-1:0] = div_q;
         ctl_rdata[DIV_W]     = cpol_q;
         ctl_rdata[DIV_W+1]   = cpha_q;
      end else if (ofs == WI_W'(CTL_OLEN)) begin
         ctl_rdata[LEN_W-1:0] = olen_q;
      end else if (ofs == WI_W'(CTL_ILEN)) begin
         ctl_rdata[LEN_W-1:0] = ilen_q;
      end
   end

   assign reg_rdata = is_ctl ? ctl_rdata : buf_rdata;

   spim_buf #(
      .WORDS  (WORDS),
      .WORD_W (WORD_W)
   ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_we_i    (buf_we),
      .sw_idx_i   (ofs),
      .sw_wdata_i (reg_wdata),
      .sw_rdata_o (buf_rdata),
      .rd_idx_i   (tx_idx),
      .rd_bit_o   (tx_bit),
      .wr_we_i    (rx_we),
      .wr_idx_i   (rx_idx),
      .wr_bit_i   (rx_bit)
   );

   spim_div #(
      .DIV_W (DIV_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_i    (div_q),
      .active_i (busy),
      .tick_o   (tick)
   );

   spim_seq #(
      .LEN_W (LEN_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_req),
      .tick_i      (tick),
      .cpol_i      (cpol_q),
      .cpha_i      (cpha_q),
      .olen_i      (olen_q),
      .ilen_i      (ilen_q),
      .tx_bit_i    (tx_bit),
      .miso_i      (miso_i),
      .busy_o      (busy),
      .finish_o    (finish),
      .sclk_o      (sclk_o),
      .mosi_o      (mosi_o),
      .cs_n_o      (cs_n_o),
      .tx_rd_idx_o (tx_idx),
      .rx_we_o     (rx_we),
      .rx_idx_o    (rx_idx),
      .rx_bit_o    (rx_bit)
   );

   assert_done_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !done_q);

   assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(div_q) && $stable(cpol_q) && $stable(cpha_q)
                                 && $stable(olen_q) && $stable(ilen_q)));

endmodule

// File: tb/spim_ctrl_bench.sv
module spim_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sclk, mosi, cs_n;
   logic        miso = 1'b0;

   always #5 clk = ~clk;

   spim_ctrl u_spim_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sclk_o    (sclk),
      .mosi_o    (mosi),
      .miso_i    (miso),
      .cs_n_o    (cs_n)
   );

   int checks = 0;
   int errors = 0;
   int total_cyc = 0;

   logic [31:0] tw [16];
   logic [31:0] mw [16];
   logic        cap [512];
   int          s_idx = 0;
   logic        s_cpol = 1'b0, s_cpha = 1'b0, lead_b;

   // edge timing monitor
   int   expect_half = 1;
   int   mcyc = 0, mlast = 0, toggles = 0, setup_gap = 0, hold_gap = 0, gap_err = 0;
   logic prev_cs = 1'b1, prev_sclk = 1'b0;

   function automatic logic [31:0] txw(int w, int s);
      return 32'h5A3C_96E1 ^ (32'(w) * 32'h9E37_79B1) ^ (32'(s) * 32'h85EB_CA6B);
   endfunction

   function automatic logic mbit(int i);
      if (i >= 512) return 1'b0;
      return mw[i / 32][31 - (i % 32)];
   endfunction

   function automatic logic tbit(int i);
      return tw[i / 32][31 - (i % 32)];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 5'(a);
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle(output bit ok);
      logic [31:0] d;
      ok = 1'b0;
      for (int k = 0; k < 60000; k++) begin
         reg_read(16, d);
         if (!d[0]) begin ok = 1'b1; break; end
      end
   endtask

   // peripheral model: samples MOSI and shifts MISO on the mode's edges
   always @(sclk) begin
      if (!cs_n) begin
         lead_b = (sclk != s_cpol);
         if (lead_b ^ s_cpha) begin
            if (s_idx < 512) cap[s_idx] = mosi;
            s_idx++;
         end else begin
            miso = mbit(s_idx);
         end
      end
   end

   always @(negedge cs_n) begin
      s_idx = 0;
      miso  = mbit(0);
   end

   always @(negedge clk) begin
      if (!cs_n && prev_cs) begin
         mcyc = 0; mlast = 0; toggles = 0; gap_err = 0;
      end else if (!cs_n) begin
         mcyc++;
         if (sclk != prev_sclk) begin
            if (toggles == 0) setup_gap = mcyc - mlast;
            else if (mcyc - mlast != expect_half) gap_err++;
            mlast = mcyc;
            toggles++;
         end
      end else if (!prev_cs) begin
         mcyc++;
         hold_gap = mcyc - mlast;
      end
      prev_cs   = cs_n;
      prev_sclk = sclk;
   end

   always @(posedge clk) begin
      total_cyc++;
      if (total_cyc == 190000) begin
         errors++;
         checks++;
         $display("FAIL watchdog R2 actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic run_xfer(input int mode, input int dv, input int ol, input int il, input int seed);
      logic [31:0] d, e;
      bit ok;
      int n, h, bad5, bad7, bad8, ii;
      logic cp, ch;
      cp = mode[1]; ch = mode[0];
      h  = (dv < 2) ? 32768 : dv / 2;
      n  = ((ol > il) ? ol : il) + 1;
      for (int w = 0; w < 16; w++) begin
         tw[w] = txw(w, seed);
         mw[w] = txw(w, seed * 3 + 11);
         reg_write(w, tw[w]);
      end
      s_cpol = cp; s_cpha = ch; expect_half = h;
      reg_write(17, (32'(ch) << 17) | (32'(cp) << 16) | 32'(dv));
      reg_write(18, 32'(ol));
      reg_write(19, 32'(il));
      check("R4 idle level", {31'b0, sclk}, {31'b0, cp});
      reg_write(16, 32'h1);
      reg_read(16, d);
      check("R2 busy", d & 32'h3, 32'h1);
      wait_idle(ok);
      check("R2 completes", {31'b0, ok}, 32'h1);
      reg_read(16, d);
      check("R2 done", d & 32'h3, 32'h2);
      check("R6 edge count", 32'(toggles), 32'(2 * n));
      check("R6 bit count", 32'(s_idx), 32'(n));
      check("R3 half period", 32'(gap_err), 32'h0);
      check("R9 setup", 32'(setup_gap), 32'(h));
      check("R9 hold", 32'(hold_gap), 32'(h));
      bad5 = 0; bad7 = 0;
      for (int i = 0; i < n; i++) begin
         if (i <= ol) begin if (cap[i] !== tbit(i)) bad5++; end
         else if (cap[i] !== 1'b0) bad7++;
      end
      check("R5 mosi stream", 32'(bad5), 32'h0);
      check("R7 mosi past length", 32'(bad7), 32'h0);
      bad8 = 0;
      for (int w = 0; w < 16; w++) begin
         reg_read(w, d);
         for (int b = 0; b < 32; b++) begin
            ii = w * 32 + 31 - b;
            e[b] = (ii <= il) ? mbit(ii) : tbit(ii);
         end
         if (d !== e) bad8++;
      end
      check("R8 receive buffer", 32'(bad8), 32'h0);
      check("R4 idle after", {31'b0, sclk}, {31'b0, cp});
   endtask

   task automatic big_div(input int dv);
      reg_write(17, 32'(dv));
      reg_write(18, 0);
      reg_write(19, 0);
      s_cpol = 1'b0; s_cpha = 1'b0; expect_half = 32768;
      reg_write(16, 1);
      for (int k = 0; k < 40000; k++) begin
         @(negedge clk);
         if (toggles >= 1 && !cs_n) break;
      end
      check("R3 divisor zero/one", 32'(setup_gap), 32'd32768);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 select after reset", {31'b0, cs_n}, 32'h1);
   endtask

   initial begin
      logic [31:0] d;
      bit ok;
      int bad, dvs [4], ols [4], ils [4], p;
      dvs = '{2, 3, 7, 10};
      ols = '{7, 40, 5, 511};
      ils = '{7, 12, 70, 511};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check("R11 cs_n", {31'b0, cs_n}, 32'h1);
      check("R11 sclk", {31'b0, sclk}, 32'h0);
      check("R11 mosi", {31'b0, mosi}, 32'h0);
      bad = 0;
      for (int a = 0; a < 20; a++) begin
         reg_read(a, d);
         if (d !== 32'h0) bad++;
      end
      check("R11 registers zero", 32'(bad), 32'h0);

      // R1 buffer write and read back
      for (int w = 0; w < 16; w++) reg_write(w, txw(w, 99));
      bad = 0;
      for (int w = 0; w < 16; w++) begin
         reg_read(w, d);
         if (d !== txw(w, 99)) bad++;
      end
      check("R1 buffer readback", 32'(bad), 32'h0);

      // sweep of modes, divisors and length pairs
      for (int m = 0; m < 4; m++) begin
         for (int di = 0; di < 4; di++) begin
            p = (m + di) % 4;
            run_xfer(m, dvs[di], ols[p], ils[p], m * 4 + di + 1);
         end
      end

      // R10 writes during a transfer
      for (int w = 0; w < 16; w++) begin
         tw[w] = txw(w, 55);
         reg_write(w, tw[w]);
      end
      reg_write(17, 32'd10);
      reg_write(18, 32'd100);
      reg_write(19, 32'd7);
      s_cpol = 1'b0; s_cpha = 1'b0; expect_half = 5;
      reg_write(16, 1);
      reg_write(5, 32'h0);
      reg_write(17, 32'h0003_0002);
      reg_write(18, 32'd3);
      reg_write(19, 32'd3);
      reg_write(16, 1);
      wait_idle(ok);
      check("R10 transfer completes", {31'b0, ok}, 32'h1);
      reg_read(5, d);
      check("R10 buffer write ignored", d, tw[5]);
      reg_read(17, d);
      check("R10 config write ignored", d, 32'd10);
      reg_read(18, d);
      check("R10 outbound length kept", d, 32'd100);
      reg_read(19, d);
      check("R10 inbound length kept", d, 32'd7);
      check("R10 edge count unchanged", 32'(toggles), 32'd202);

      // R3 divisor fields 0 and 1
      big_div(0);
      big_div(1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule